// File: doc/BRIEF.md
# Multi-Cycle Instruction Step Sequencer

This block is the control state machine of a small multi-cycle load/store register machine. It moves each instruction through up to five phases (fetch, decode with operand read, execute, memory access, write-back) and raises the per-phase strobes that steer an external datapath. These strobes are PC update, PC target select, ALU start, memory read, memory write and register-file write. The phase is also shown as a one-hot vector. The instruction class is given by the decoder during the decode phase and held inside the sequencer for the rest of the instruction.

How long an instruction takes depends on its class. ALU operations and loads use five cycles. Stores finish after their memory access and use four. Branches finish in execute after four cycles, because they spend two cycles there: one to compare and one to redirect the PC. Two free-running counters record elapsed cycles and retired instructions. Dividing one by the other gives the average cycles per instruction for any instruction mix.

Top module: `step_sequencer`

## Requirements
- R1: `phase_o` is one-hot with bit 0 fetch, bit 1 decode, bit 2 execute, bit 3 memory, bit 4 write-back. Phases are visited in that order. `instr_class_i` (0 ALU, 1 load, 2 store, 3 branch) is sampled in the decode cycle only, and later changes to it have no effect on the current instruction.
- R2: An ALU instruction takes 5 cycles: fetch, decode, execute, a memory slot with neither memory strobe, then write-back.
- R3: A load takes 5 cycles. `mem_rd_o` is high in its memory cycle and `rf_we_o` is high in its write-back cycle.
- R4: A store takes 4 cycles and ends after the memory cycle, in which `mem_wr_o` is high. It has no write-back.
- R5: A branch takes 4 cycles: fetch, decode and two execute cycles. In the second execute cycle `pc_update_o` and `pc_target_o` are both high if `branch_taken_i` is high, and both low otherwise.
- R6: `pc_update_o` is high in every fetch cycle with `pc_target_o` low. `alu_start_o` is high only in the first execute cycle of each instruction.
- R7: `instr_done_o` is high in the last cycle of each instruction, and the next cycle is a fetch with no idle cycle between.
- R8: A synchronous reset, even in the middle of an instruction, returns the phase to fetch and clears both counters.
- R9: `rf_we_o` is high only in the write-back phase, and only for ALU and load instructions.
- R10: `cycle_count_o` increases by one on every clock after reset, and `retired_count_o` increases by one per completed instruction. A mix of 4 ALU, 2 load, 2 store and 2 branch instructions gives 46 cycles for 10 retired, a ratio of 4.6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_class_i | input | 2 | Instruction class, sampled in decode |
| branch_taken_i | input | 1 | Branch outcome, sampled in the second branch execute cycle |
| phase_o | output | 5 | One-hot current phase |
| pc_update_o | output | 1 | Load the PC this cycle |
| pc_target_o | output | 1 | PC source is the branch target, not the sequential address |
| alu_start_o | output | 1 | Start the ALU operation |
| mem_rd_o | output | 1 | Data memory read |
| mem_wr_o | output | 1 | Data memory write |
| rf_we_o | output | 1 | Register-file write |
| instr_done_o | output | 1 | Last cycle of the current instruction |
| cycle_count_o | output | CNT_W | Cycles since reset |
| retired_count_o | output | CNT_W | Instructions completed since reset |

## Verification
Completion of one instruction and the start of the next occur on a single clock edge: the final phase strobes, the retirement count and the return to fetch all happen together. The bench provokes this by running every ordered pair of classes back to back, with branches both taken and not taken. It then checks cycle by cycle that the final phase is followed directly by a fetch, and that both counters match the summed class lengths. A reset during execute is also checked, to confirm that it overrides the normal next phase.

// File: rtl/step_seq_pkg.sv
package step_seq_pkg;

    localparam int unsigned NUM_PHASES = 5;

    typedef enum logic [2:0] {
        PH_FETCH  = 3'd0,
        PH_DECODE = 3'd1,
        PH_EXEC   = 3'd2,
        PH_MEM    = 3'd3,
        PH_WB     = 3'd4
    } phase_e;

    typedef enum logic [1:0] {
        CL_ALU    = 2'd0,
        CL_LOAD   = 2'd1,
        CL_STORE  = 2'd2,
        CL_BRANCH = 2'd3
    } iclass_e;

    typedef struct packed {
        phase_e  phase;
        iclass_e cls;
        logic    br_second;
    } seq_state_t;

endpackage

// File: rtl/step_fsm.sv
module step_fsm
    import step_seq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  iclass_e cls_i,
    output phase_e  phase_o,
    output iclass_e cls_o,
    output logic    br_second_o,
    output logic    last_o
);

    seq_state_t state_d, state_q;
    logic       last_d;

    always_comb begin
        state_d = state_q;
        last_d  = 1'b0;
        unique case (state_q.phase)
            PH_FETCH: begin
                state_d.phase     = PH_DECODE;
                state_d.br_second = 1'b0;
            end
            PH_DECODE: begin
                state_d.cls   = cls_i;
                state_d.phase = PH_EXEC;
            end
            PH_EXEC: begin
                if (state_q.cls == CL_BRANCH) begin
                    if (state_q.br_second) begin
                        last_d            = 1'b1;
                        state_d.phase     = PH_FETCH;
                        state_d.br_second = 1'b0;
                    end else begin
                        state_d.br_second = 1'b1;
                    end
                end else begin
                    state_d.phase = PH_MEM;
                end
            end
            PH_MEM: begin
                if (state_q.cls == CL_STORE) begin
                    last_d        = 1'b1;
                    state_d.phase = PH_FETCH;
                end else begin
                    state_d.phase = PH_WB;
                end
            end
            PH_WB: begin
                last_d        = 1'b1;
                state_d.phase = PH_FETCH;
            end
            default: begin
                state_d.phase = PH_FETCH;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '{phase: PH_FETCH, cls: CL_ALU, br_second: 1'b0};
        end else begin
            state_q <= state_d;
        end
    end

    assign phase_o     = state_q.phase;
    assign cls_o       = state_q.cls;
    assign br_second_o = state_q.br_second;
    assign last_o      = last_d;

endmodule

// File: rtl/step_strobes.sv
module step_strobes
    import step_seq_pkg::*;
(
    input  phase_e                  phase_i,
    input  iclass_e                 cls_i,
    input  logic                    br_second_i,
    input  logic                    taken_i,
    output logic [NUM_PHASES-1:0]   phase_oh_o,
    output logic                    pc_update_o,
    output logic                    pc_target_o,
    output logic                    alu_start_o,
    output logic                    mem_rd_o,
    output logic                    mem_wr_o,
    output logic                    rf_we_o
);

    for (genvar g = 0; g < NUM_PHASES; g++) begin : g_oh
        assign phase_oh_o[g] = (int'(phase_i) == g);
    end

    logic redirect;

    always_comb begin
        redirect    = (phase_i == PH_EXEC) && (cls_i == CL_BRANCH) && br_second_i && taken_i;
        pc_update_o = (phase_i == PH_FETCH) || redirect;
        pc_target_o = redirect;
        alu_start_o = (phase_i == PH_EXEC) && !br_second_i;
        mem_rd_o    = (phase_i == PH_MEM) && (cls_i == CL_LOAD);
        mem_wr_o    = (phase_i == PH_MEM) && (cls_i == CL_STORE);
        rf_we_o     = (phase_i == PH_WB) && ((cls_i == CL_ALU) || (cls_i == CL_LOAD));
    end

endmodule

// File: rtl/perf_counter.sv
module perf_counter #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc_i,
    output logic [W-1:0] count_o
);

    logic [W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q + W'(inc_i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

    assign count_o = count_q;

endmodule

// File: rtl/step_sequencer.sv
module step_sequencer
    import step_seq_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       instr_class_i,
    input  logic             branch_taken_i,
    output logic [4:0]       phase_o,
    output logic             pc_update_o,
    output logic             pc_target_o,
    output logic             alu_start_o,
    output logic             mem_rd_o,
    output logic             mem_wr_o,
    output logic             rf_we_o,
    output logic             instr_done_o,
    output logic [CNT_W-1:0] cycle_count_o,
    output logic [CNT_W-1:0] retired_count_o
);

    phase_e  phase;
    iclass_e cls;
    logic    br_second;
    logic    last;

    step_fsm i_fsm (
        .clk         (clk),
        .rst         (rst),
        .cls_i       (iclass_e'(instr_class_i)),
        .phase_o     (phase),
        .cls_o       (cls),
        .br_second_o (br_second),
        .last_o      (last)
    );

    step_strobes i_strobes (
        .phase_i     (phase),
        .cls_i       (cls),
        .br_second_i (br_second),
        .taken_i     (branch_taken_i),
        .phase_oh_o  (phase_o),
        .pc_update_o (pc_update_o),
        .pc_target_o (pc_target_o),
        .alu_start_o (alu_start_o),
        .mem_rd_o    (mem_rd_o),
        .mem_wr_o    (mem_wr_o),
        .rf_we_o     (rf_we_o)
    );

    perf_counter #(.W(CNT_W)) i_cycles (
        .clk     (clk),
        .rst     (rst),
        .inc_i   (1'b1),
        .count_o (cycle_count_o)
    );

    perf_counter #(.W(CNT_W)) i_retired (
        .clk     (clk),
        .rst     (rst),
        .inc_i   (last),
        .count_o (retired_count_o)
    );

    assign instr_done_o = last;

endmodule

// File: rtl/step_sequencer_chk.sv
module step_sequencer_chk #(
    parameter int unsigned CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic [4:0]       phase_o,
    input logic             rf_we_o,
    input logic             mem_rd_o,
    input logic             mem_wr_o,
    input logic             instr_done_o,
    input logic [CNT_W-1:0] cycle_count_o,
    input logic [CNT_W-1:0] retired_count_o
);

    // R1
    phase_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(phase_o) == 1);

    // R9
    wb_only_write_chk: assert property (@(posedge clk) disable iff (rst)
        rf_we_o |-> phase_o[4]);

    // R4
    mem_strobe_phase_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_o || mem_wr_o) |-> phase_o[3]);

    // R7
    fetch_follows_done_chk: assert property (@(posedge clk) disable iff (rst)
        instr_done_o |=> phase_o[0]);

    // R10
    cycle_step_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> cycle_count_o == $past(cycle_count_o) + 1'b1);

    // R10
    retire_step_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> retired_count_o == $past(retired_count_o) + CNT_W'($past(instr_done_o)));

    // R8
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cycle_count_o == '0 && retired_count_o == '0 && phase_o == 5'b00001));

endmodule

bind step_sequencer step_sequencer_chk #(.CNT_W(CNT_W)) i_step_chk (
    .clk             (clk),
    .rst             (rst),
    .phase_o         (phase_o),
    .rf_we_o         (rf_we_o),
    .mem_rd_o        (mem_rd_o),
    .mem_wr_o        (mem_wr_o),
    .instr_done_o    (instr_done_o),
    .cycle_count_o   (cycle_count_o),
    .retired_count_o (retired_count_o)
);

// File: tb/test_step_sequencer.sv
module test_step_sequencer;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 32;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [1:0]       instr_class_i = 2'd0;
    logic             branch_taken_i = 1'b0;
    logic [4:0]       phase_o;
    logic             pc_update_o, pc_target_o, alu_start_o;
    logic             mem_rd_o, mem_wr_o, rf_we_o, instr_done_o;
    logic [CNT_W-1:0] cycle_count_o, retired_count_o;

    int n_checks = 0;
    int n_fail   = 0;
    int tot_cyc  = 0;
    int tot_ret  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    step_sequencer #(.CNT_W(CNT_W)) i_step_sequencer (
        .clk             (clk),
        .rst             (rst),
        .instr_class_i   (instr_class_i),
        .branch_taken_i  (branch_taken_i),
        .phase_o         (phase_o),
        .pc_update_o     (pc_update_o),
        .pc_target_o     (pc_target_o),
        .alu_start_o     (alu_start_o),
        .mem_rd_o        (mem_rd_o),
        .mem_wr_o        (mem_wr_o),
        .rf_we_o         (rf_we_o),
        .instr_done_o    (instr_done_o),
        .cycle_count_o   (cycle_count_o),
        .retired_count_o (retired_count_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Strobe vector order: {pc_update, pc_target, alu_start, mem_rd, mem_wr, rf_we, done}
    task automatic run_instr(input logic [1:0] c, input logic t);
        int len;
        len = (c < 2) ? 5 : 4;
        instr_class_i  = c;
        branch_taken_i = t;
        for (int k = 0; k < len; k++) begin
            logic [4:0] exp_ph;
            logic [6:0] exp_sb;
            string      req;
            if (k == 2) instr_class_i = ~c; // R1: late class change ignored
            exp_ph = (c == 2'd3 && k == 3) ? 5'b00100 : 5'(1 << k);
            exp_sb = '0;
            case (c)
                2'd0: req = "R2";
                2'd1: req = "R3";
                2'd2: req = "R4";
                default: req = "R5";
            endcase
            if (k == 0) exp_sb[6] = 1'b1;           // R6 fetch
            if (k == 2) exp_sb[4] = 1'b1;           // R6 alu start
            if (k == 3 && c == 2'd1) exp_sb[3] = 1'b1;
            if (k == 3 && c == 2'd2) exp_sb[2] = 1'b1;
            if (k == 3 && c == 2'd3) begin
                exp_sb[6] = t;
                exp_sb[5] = t;
            end
            if (k == 4) exp_sb[1] = 1'b1;           // R9
            if (k == len - 1) exp_sb[0] = 1'b1;     // R7
            check({req, " R1 phase"}, 32'(phase_o), 32'(exp_ph));
            check({req, " R6 R9 R7 strobes"},
                  32'({pc_update_o, pc_target_o, alu_start_o, mem_rd_o, mem_wr_o, rf_we_o, instr_done_o}),
                  32'(exp_sb));
            @(negedge clk);
        end
        tot_cyc += len;
        tot_ret += 1;
        check("R7 fetch follows", 32'(phase_o), 32'h1);
        check("R10 cycles", cycle_count_o, 32'(tot_cyc));
        check("R10 retired", retired_count_o, 32'(tot_ret));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8 reset phase", 32'(phase_o), 32'h1);
        check("R8 reset cycles", cycle_count_o, 0);
        check("R8 reset retired", retired_count_o, 0);
        rst = 1'b0;

        for (int t = 0; t < 2; t++)
            for (int a = 0; a < 4; a++)
                for (int b = 0; b < 4; b++) begin
                    run_instr(2'(a), t[0]);
                    run_instr(2'(b), ~t[0]);
                end

        // R8: reset during execute of a store
        instr_class_i = 2'd2;
        repeat (2) @(negedge clk);
        check("R8 mid phase exec", 32'(phase_o), 32'h4);
        rst = 1'b1;
        @(negedge clk);
        check("R8 mid reset phase", 32'(phase_o), 32'h1);
        check("R8 mid reset cycles", cycle_count_o, 0);
        check("R8 mid reset retired", retired_count_o, 0);
        rst = 1'b0;
        tot_cyc = 0;
        tot_ret = 0;

        // R10: 40% ALU, 20% each load/store/branch
        run_instr(2'd0, 1'b0); run_instr(2'd1, 1'b0); run_instr(2'd3, 1'b1);
        run_instr(2'd0, 1'b0); run_instr(2'd2, 1'b0); run_instr(2'd0, 1'b0);
        run_instr(2'd3, 1'b0); run_instr(2'd1, 1'b0); run_instr(2'd2, 1'b0);
        run_instr(2'd0, 1'b0);
        check("R10 mix cycles", cycle_count_o, 46);
        check("R10 mix retired", retired_count_o, 10);
        check("R10 ratio 4.6", 32'(cycle_count_o * 10), 32'(retired_count_o * 46));

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule